// File: doc/BRIEF.md
# Half-Word Host Bus to DWORD Bridge

This block joins a 16-bit host bus to an internal 32-bit register and data-FIFO side. The host moves one 32-bit word as two 16-bit strobes, one to each half of the word. The halves may come in either order. For a write, the block holds the first half. It issues a single 32-bit write strobe when the matching other half arrives. For a read, the first half fetches the whole word from the internal side and keeps a copy. The second half is served from that copy, so a FIFO is popped only once per word.

Both halves must name the same DWORD. That means the same address bits from bit 2 up, and the same FIFO-select level. A half that names a different DWORD abandons the pending one and starts a new pair. A second write to the half already held cancels the pair and commits nothing. A second read of the half already read returns data flagged as invalid and clears the read pairing. The next read then starts fresh.

Data-FIFO traffic can use big-endian byte order. The host reaches the FIFOs in two ways: through a low address window, or by asserting a FIFO-select input. Each way has its own order control bit. All other addresses always use little-endian order. Host strobes are single-cycle and synchronous to the clock. Read data returns one cycle after the read strobe.

Top module: `host_half_bridge`

## Requirements
- R1: Synchronous active-high reset clears all pairing state and held data. After reset `hostRdAck`, `hostRdErr` and `hostRdata` are 0. A write half taken before reset never pairs with a half taken after it.
- R2: A write half followed by a write to the other half of the same DWORD gives `intWrEn` high in the cycle of the second strobe. `intAddr` is the DWORD address, and `intWdata` has the half at byte-address bit 1 = 0 in bits 15:0 and the half at bit 1 = 1 in bits 31:16.
- R3: The high half may be written or read before the low half, with the same resulting word as the other order.
- R4: A second write to the same half as the held write half commits nothing and clears the pair. The next write is then treated as a first half.
- R5: An access whose address bits 2 and up (or FIFO-select level) differ from the pending half drops the pending half and becomes the first half of a new pair. For a read this fetches again.
- R6: The first half of a read raises `intRdEn` for one cycle and captures the word. The other half raises no `intRdEn` and returns the captured word's other half.
- R7: A second read of the same half raises `hostRdErr` with its acknowledge, does not fetch, and clears the read pair. The next read fetches anew.
- R8: An access with FIFO-select low and byte address below `FIFO_WIN_BYTES` (64) uses `cfgPortBig`. Value 1 reverses the four bytes of the word (byte 0 swaps with byte 3, byte 1 with byte 2); value 0 keeps little-endian order.
- R9: With `hostFifoSel` high, byte order follows `cfgSelBig` with the same encoding, whatever the address and `cfgPortBig`.
- R10: With FIFO-select low and address at or above the window, the order is little-endian whatever the control bits.
- R11: Every accepted read raises `hostRdAck` exactly one cycle after its strobe, with the half on `hostRdata`.
- R12: When `hostWr` and `hostRd` are high together, only the write is taken. No fetch and no acknowledge occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWr | input | 1 | Host write strobe, one cycle per half |
| hostRd | input | 1 | Host read strobe, one cycle per half |
| hostAddr | input | ADDR_W-1 | Half-word address, byte-address bits ADDR_W-1 down to 1 |
| hostFifoSel | input | 1 | Routes the access to the data FIFOs |
| hostWdata | input | 16 | Write half |
| hostRdata | output | 16 | Read half, valid with hostRdAck |
| hostRdAck | output | 1 | Read response, one cycle after hostRd |
| hostRdErr | output | 1 | Response is invalid (repeated half) |
| cfgPortBig | input | 1 | Byte order for the FIFO address window |
| cfgSelBig | input | 1 | Byte order for FIFO-select accesses |
| intWrEn | output | 1 | 32-bit internal write strobe |
| intRdEn | output | 1 | 32-bit internal read (pop) strobe |
| intAddr | output | ADDR_W-2 | DWORD address |
| intFifoSel | output | 1 | Internal access is a FIFO-select access |
| intWdata | output | 32 | 32-bit write word |
| intRdata | input | 32 | 32-bit read word, valid in the intRdEn cycle |

## Verification
The hardest states to reach are the ones where a pending half meets an access that does not complete it. Examples are a repeated half, a half of a neighbouring DWORD, or a reset between the halves. The table walks through these on purpose. A dropped write is followed by a single write to the other half, which must not commit, and then by a completing write, which must. A repeated read is followed by a read that must fetch again. A read of a new DWORD is placed while a read is pending. Directed steps then cover reset between two write halves and a cycle with both strobes high.

// File: rtl/hb_pkg.sv
package hb_pkg;

  typedef struct packed {
    logic holdWr;    // keep the incoming write half
    logic commitWr;  // assemble and issue the 32-bit write
    logic fetchRd;   // pop/read the internal word and capture it
    logic respond;   // return a half to the host next cycle
    logic rdErr;     // the returned half is flagged invalid
    logic bigOrder;  // byte-reverse the word for this access
    logic half;      // which half this access targets
  } hbStrobe_t;

  function automatic logic [31:0] byteRev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/hb_ctrl.sv
module hb_ctrl
  import hb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int FIFO_WIN_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:1] hostAddr,
  input  logic              hostFifoSel,
  input  logic              cfgPortBig,
  input  logic              cfgSelBig,
  output hbStrobe_t         stb
);
  localparam int TAG_W = ADDR_W - 1;  // FIFO-select plus DWORD address

  logic             pending;
  logic             pendRead;
  logic             pendHalf;
  logic [TAG_W-1:0] pendTag;

  logic [TAG_W-1:0] curTag;
  logic             curHalf;
  logic             tagHit;
  logic             otherHalf;
  logic             doWr;
  logic             doRd;
  logic             inWindow;

  assign curTag    = {hostFifoSel, hostAddr[ADDR_W-1:2]};
  assign curHalf   = hostAddr[1];
  assign tagHit    = pending && (pendTag == curTag);
  assign otherHalf = (pendHalf != curHalf);
  assign doWr      = hostWr;
  assign doRd      = hostRd && !hostWr;
  assign inWindow  = ({hostAddr, 1'b0} < ADDR_W'(FIFO_WIN_BYTES));

  always_comb begin
    stb          = '0;
    stb.half     = curHalf;
    stb.bigOrder = hostFifoSel ? cfgSelBig : (inWindow && cfgPortBig);
    if (doWr) begin
      if (tagHit && !pendRead) stb.commitWr = otherHalf;
      else                     stb.holdWr   = 1'b1;
    end else if (doRd) begin
      stb.respond = 1'b1;
      if (tagHit && pendRead) stb.rdErr   = !otherHalf;
      else                    stb.fetchRd = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      pendRead <= 1'b0;
      pendHalf <= 1'b0;
      pendTag  <= '0;
    end else if (doWr || doRd) begin
      if (tagHit && (pendRead == doRd)) begin
        pending <= 1'b0;  // pair completed, or repeated half cancels it
      end else begin
        pending  <= 1'b1;
        pendRead <= doRd;
        pendHalf <= curHalf;
        pendTag  <= curTag;
      end
    end
  end

  // R1: nothing is pending in the first cycle after reset
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pending);

  // R2: a commit closes the write pair
  p_commit_closes_r2: assert property (@(posedge clk) disable iff (rst)
    stb.commitWr |=> !pending);

  // R4: a repeated write half leaves nothing pending
  p_drop_closes_r4: assert property (@(posedge clk) disable iff (rst)
    (doWr && tagHit && !pendRead && !otherHalf) |=> !pending);

  // R6: a fetch opens a read pair
  p_fetch_opens_r6: assert property (@(posedge clk) disable iff (rst)
    stb.fetchRd |=> (pending && pendRead));

endmodule

// File: rtl/hb_datapath.sv
module hb_datapath
  import hb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  hbStrobe_t   stb,
  input  logic [15:0] hostWdata,
  input  logic [31:0] intRdata,
  output logic [31:0] intWdata,
  output logic [15:0] hostRdata,
  output logic        hostRdAck,
  output logic        hostRdErr
);
  logic [15:0] holdHalf;
  logic [31:0] snapshot;
  logic [31:0] assembled;
  logic [31:0] fetched;
  logic [31:0] rdWord;

  assign assembled = stb.half ? {hostWdata, holdHalf} : {holdHalf, hostWdata};
  assign intWdata  = stb.bigOrder ? byteRev(assembled) : assembled;
  assign fetched   = stb.bigOrder ? byteRev(intRdata) : intRdata;
  assign rdWord    = stb.fetchRd ? fetched : snapshot;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdHalf  <= '0;
      snapshot  <= '0;
      hostRdata <= '0;
      hostRdAck <= 1'b0;
      hostRdErr <= 1'b0;
    end else begin
      if (stb.holdWr)  holdHalf <= hostWdata;
      if (stb.fetchRd) snapshot <= fetched;
      if (stb.respond) hostRdata <= stb.half ? rdWord[31:16] : rdWord[15:0];
      hostRdAck <= stb.respond;
      hostRdErr <= stb.rdErr;
    end
  end

  // R11: a read response follows its strobe by one cycle
  p_ack_after_respond_r11: assert property (@(posedge clk) disable iff (rst)
    stb.respond |=> hostRdAck);

  // R7: an invalid flag only comes with a response
  p_err_has_ack_r7: assert property (@(posedge clk) disable iff (rst)
    hostRdErr |-> hostRdAck);

endmodule

// File: rtl/host_half_bridge.sv
module host_half_bridge
  import hb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int FIFO_WIN_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:1] hostAddr,
  input  logic              hostFifoSel,
  input  logic [15:0]       hostWdata,
  output logic [15:0]       hostRdata,
  output logic              hostRdAck,
  output logic              hostRdErr,
  input  logic              cfgPortBig,
  input  logic              cfgSelBig,
  output logic              intWrEn,
  output logic              intRdEn,
  output logic [ADDR_W-1:2] intAddr,
  output logic              intFifoSel,
  output logic [31:0]       intWdata,
  input  logic [31:0]       intRdata
);
  hbStrobe_t stb;

  hb_ctrl #(.ADDR_W(ADDR_W), .FIFO_WIN_BYTES(FIFO_WIN_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(hostAddr), .hostFifoSel(hostFifoSel),
    .cfgPortBig(cfgPortBig), .cfgSelBig(cfgSelBig), .stb(stb)
  );

  hb_datapath u_dp (
    .clk(clk), .rst(rst), .stb(stb), .hostWdata(hostWdata),
    .intRdata(intRdata), .intWdata(intWdata), .hostRdata(hostRdata),
    .hostRdAck(hostRdAck), .hostRdErr(hostRdErr)
  );

  assign intWrEn    = stb.commitWr;
  assign intRdEn    = stb.fetchRd;
  assign intAddr    = hostAddr[ADDR_W-1:2];
  assign intFifoSel = hostFifoSel;

  // R12: a write cycle never fetches
  p_wr_blocks_rd_r12: assert property (@(posedge clk) disable iff (rst)
    hostWr |-> !intRdEn);

  // R12: a cycle with both strobes is never acknowledged as a read
  p_no_ack_on_wr_r12: assert property (@(posedge clk) disable iff (rst)
    hostWr |=> !hostRdAck);

endmodule

// File: tb/host_half_bridge_tb.sv
`timescale 1ns/1ps
module host_half_bridge_tb;
  localparam int ADDR_W = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostWr = 1'b0, hostRd = 1'b0, hostFifoSel = 1'b0;
  logic [7:0]  addrByte = '0;
  logic [15:0] hostWdata = '0;
  logic        cfgPortBig = 1'b0, cfgSelBig = 1'b0;
  logic [15:0] hostRdata;
  logic        hostRdAck, hostRdErr, intWrEn, intRdEn, intFifoSel;
  logic [7:2]  intAddr;
  logic [31:0] intWdata, intRdata;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  // internal word model: top byte carries the DWORD address
  assign intRdata = {2'b10, intAddr, 24'h345678};

  host_half_bridge #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rst(rst), .hostWr(hostWr), .hostRd(hostRd),
    .hostAddr(addrByte[7:1]), .hostFifoSel(hostFifoSel),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .hostRdAck(hostRdAck),
    .hostRdErr(hostRdErr), .cfgPortBig(cfgPortBig), .cfgSelBig(cfgSelBig),
    .intWrEn(intWrEn), .intRdEn(intRdEn), .intAddr(intAddr),
    .intFifoSel(intFifoSel), .intWdata(intWdata), .intRdata(intRdata)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        isRd;
    logic        fs;
    logic        pb;
    logic        sb;
    logic [7:0]  addr;
    logic [15:0] wd;
    logic        expWr;
    logic [31:0] expW;
    logic        expRdEn;
    logic        expErr;
    logic [15:0] expRd;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t TBL [NV] = '{
    '{4'd2, 1'b0,1'b0,1'b0,1'b0, 8'h44, 16'h1111, 1'b0, 32'h0,        1'b0,1'b0,16'h0},
    '{4'd2, 1'b0,1'b0,1'b0,1'b0, 8'h46, 16'h2222, 1'b1, 32'h22221111, 1'b0,1'b0,16'h0}, // R2
    '{4'd3, 1'b0,1'b0,1'b0,1'b0, 8'h4A, 16'h3333, 1'b0, 32'h0,        1'b0,1'b0,16'h0},
    '{4'd3, 1'b0,1'b0,1'b0,1'b0, 8'h48, 16'h4444, 1'b1, 32'h33334444, 1'b0,1'b0,16'h0}, // R3
    '{4'd4, 1'b0,1'b0,1'b0,1'b0, 8'h50, 16'hAAAA, 1'b0, 32'h0,        1'b0,1'b0,16'h0},
    '{4'd4, 1'b0,1'b0,1'b0,1'b0, 8'h50, 16'hBBBB, 1'b0, 32'h0,        1'b0,1'b0,16'h0}, // R4 drop
    '{4'd4, 1'b0,1'b0,1'b0,1'b0, 8'h52, 16'hCCCC, 1'b0, 32'h0,        1'b0,1'b0,16'h0}, // R4 fresh first
    '{4'd4, 1'b0,1'b0,1'b0,1'b0, 8'h50, 16'hDDDD, 1'b1, 32'hCCCCDDDD, 1'b0,1'b0,16'h0},
    '{4'd5, 1'b0,1'b0,1'b0,1'b0, 8'h60, 16'h0101, 1'b0, 32'h0,        1'b0,1'b0,16'h0},
    '{4'd5, 1'b0,1'b0,1'b0,1'b0, 8'h66, 16'h0202, 1'b0, 32'h0,        1'b0,1'b0,16'h0}, // R5 abandon
    '{4'd5, 1'b0,1'b0,1'b0,1'b0, 8'h64, 16'h0303, 1'b1, 32'h02020303, 1'b0,1'b0,16'h0},
    '{4'd8, 1'b0,1'b0,1'b1,1'b0, 8'h10, 16'h1234, 1'b0, 32'h0,        1'b0,1'b0,16'h0},
    '{4'd8, 1'b0,1'b0,1'b1,1'b0, 8'h12, 16'h5678, 1'b1, 32'h34127856, 1'b0,1'b0,16'h0}, // R8
    '{4'd9, 1'b0,1'b1,1'b0,1'b1, 8'h10, 16'h1234, 1'b0, 32'h0,        1'b0,1'b0,16'h0},
    '{4'd9, 1'b0,1'b1,1'b0,1'b1, 8'h12, 16'h5678, 1'b1, 32'h34127856, 1'b0,1'b0,16'h0}, // R9
    '{4'd9, 1'b0,1'b1,1'b1,1'b0, 8'h90, 16'hAAAA, 1'b0, 32'h0,        1'b0,1'b0,16'h0},
    '{4'd9, 1'b0,1'b1,1'b1,1'b0, 8'h92, 16'h5555, 1'b1, 32'h5555AAAA, 1'b0,1'b0,16'h0}, // R9
    '{4'd10,1'b0,1'b0,1'b1,1'b1, 8'h80, 16'h1234, 1'b0, 32'h0,        1'b0,1'b0,16'h0},
    '{4'd10,1'b0,1'b0,1'b1,1'b1, 8'h82, 16'h5678, 1'b1, 32'h56781234, 1'b0,1'b0,16'h0}, // R10
    '{4'd6, 1'b1,1'b0,1'b1,1'b0, 8'h84, 16'h0,    1'b0, 32'h0,        1'b1,1'b0,16'h5678},
    '{4'd6, 1'b1,1'b0,1'b1,1'b0, 8'h86, 16'h0,    1'b0, 32'h0,        1'b0,1'b0,16'hA134}, // R6
    '{4'd8, 1'b1,1'b0,1'b1,1'b0, 8'h0E, 16'h0,    1'b0, 32'h0,        1'b1,1'b0,16'h7856}, // R3 high first
    '{4'd8, 1'b1,1'b0,1'b1,1'b0, 8'h0C, 16'h0,    1'b0, 32'h0,        1'b0,1'b0,16'h3483}, // R8
    '{4'd7, 1'b1,1'b0,1'b0,1'b0, 8'h20, 16'h0,    1'b0, 32'h0,        1'b1,1'b0,16'h5678},
    '{4'd7, 1'b1,1'b0,1'b0,1'b0, 8'h20, 16'h0,    1'b0, 32'h0,        1'b0,1'b1,16'h5678}, // R7 repeat
    '{4'd7, 1'b1,1'b0,1'b0,1'b0, 8'h22, 16'h0,    1'b0, 32'h0,        1'b1,1'b0,16'h8834}, // R7 refetch
    '{4'd7, 1'b1,1'b0,1'b0,1'b0, 8'h20, 16'h0,    1'b0, 32'h0,        1'b0,1'b0,16'h5678},
    '{4'd9, 1'b1,1'b1,1'b0,1'b1, 8'hF0, 16'h0,    1'b0, 32'h0,        1'b1,1'b0,16'h34BC},
    '{4'd9, 1'b1,1'b1,1'b0,1'b1, 8'hF2, 16'h0,    1'b0, 32'h0,        1'b0,1'b0,16'h7856}, // R9
    '{4'd5, 1'b1,1'b0,1'b0,1'b0, 8'h24, 16'h0,    1'b0, 32'h0,        1'b1,1'b0,16'h5678},
    '{4'd5, 1'b1,1'b0,1'b0,1'b0, 8'h2A, 16'h0,    1'b0, 32'h0,        1'b1,1'b0,16'h8A34}, // R5 read
    '{4'd5, 1'b1,1'b0,1'b0,1'b0, 8'h28, 16'h0,    1'b0, 32'h0,        1'b0,1'b0,16'h5678}
  };

  task automatic check(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // drive at negedge, sample strobes mid-cycle, sample response after the edge
  task automatic access(input vec_t v, input logic both);
    @(negedge clk);
    hostWr = !v.isRd || both;
    hostRd = v.isRd || both;
    hostFifoSel = v.fs; cfgPortBig = v.pb; cfgSelBig = v.sb;
    addrByte = v.addr; hostWdata = v.wd;
    #1;
    check(v.req, "intWrEn", {31'b0, intWrEn}, {31'b0, v.expWr});
    if (v.expWr) begin
      check(v.req, "intWdata", intWdata, v.expW);
      check(v.req, "intAddr", {26'b0, intAddr}, {26'b0, v.addr[7:2]});
    end
    check(v.req, "intRdEn", {31'b0, intRdEn}, {31'b0, v.expRdEn});
    @(posedge clk); #1;
    hostWr = 1'b0; hostRd = 1'b0;
    check(v.isRd && !both ? 11 : v.req, "hostRdAck",
          {31'b0, hostRdAck}, {31'b0, v.isRd && !both});
    if (v.isRd && !both) begin
      check(v.req, "hostRdErr", {31'b0, hostRdErr}, {31'b0, v.expErr});
      check(v.req, "hostRdata", {16'b0, hostRdata}, {16'b0, v.expRd});
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    // R1 reset state
    check(1, "hostRdAck after reset", {31'b0, hostRdAck}, 32'd0);
    check(1, "hostRdErr after reset", {31'b0, hostRdErr}, 32'd0);
    check(1, "hostRdata after reset", {16'b0, hostRdata}, 32'd0);
    check(1, "intWrEn idle", {31'b0, intWrEn}, 32'd0);

    for (int i = 0; i < NV; i++) access(TBL[i], 1'b0);

    // R1: a half written before reset must not pair after it
    access('{4'd1, 1'b0,1'b0,1'b0,1'b0, 8'h44, 16'h9999, 1'b0, 32'h0, 1'b0,1'b0,16'h0}, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    access('{4'd1, 1'b0,1'b0,1'b0,1'b0, 8'h46, 16'h7777, 1'b0, 32'h0, 1'b0,1'b0,16'h0}, 1'b0);
    access('{4'd1, 1'b0,1'b0,1'b0,1'b0, 8'h44, 16'h6666, 1'b1, 32'h77776666, 1'b0,1'b0,16'h0}, 1'b0);

    // R12: both strobes high -> write only, no fetch, no acknowledge
    access('{4'd12, 1'b0,1'b0,1'b0,1'b0, 8'h30, 16'hABCD, 1'b0, 32'h0, 1'b0,1'b0,16'h0}, 1'b1);
    access('{4'd12, 1'b0,1'b0,1'b0,1'b0, 8'h32, 16'hEF01, 1'b1, 32'hEF01ABCD, 1'b0,1'b0,16'h0}, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule